// File: doc/BRIEF.md
# USB Host Controller Command and Status Registers

This block is the software-facing command and status interface of a USB host controller. It decodes single-cycle register writes and combinational reads on a small memory-mapped bus. It turns the command fields into control lines for a schedule engine: run, periodic enable, asynchronous enable, frame-list size, a doorbell request and a soft-reset request. It also turns the engine's handshakes back into status: pipeline idle, cache eviction done, and the end of reset.

The command fields are live handshakes rather than plain storage:

- **Doorbell.** The doorbell stays pending until the engine reports that it has evicted its cached asynchronous state. At that point the block raises the async-advance status flag and clears the doorbell.
- **Halted flag.** Clearing run does not halt the controller at once. The halted flag waits until the engine reports that its pipeline is idle.
- **Soft reset.** A write that starts a soft reset returns every operational register to its default. The reset cannot be ended by software and lasts a fixed, parameterised number of cycles.

The async-advance interrupt is gated by an enable bit and is raised only on an interrupt-threshold tick. The block also masks the running frame index down to the list index width that the selected frame-list size calls for.

Top module: `usb_hc_cmdsts`

## Requirements
- R1: After hardware reset the command word at offset 0x20 reads 0, the status word at 0x24 reads 0x1000 (halted flag in bit 12 set, async-advance flag in bit 5 clear), the enable word at 0x28 reads 0, and the interrupt output is low.
- R2: The command word fields are placed as follows. Bit 0 is run, bit 4 is periodic enable and bit 5 is asynchronous enable. Each is stored by a write to 0x20, drives its output from the cycle after the write, and reads back in place.
- R3: The frame-list size field is bits 3:2 of 0x20. The encoding is 00 for 1024 entries, 01 for 512 and 10 for 256. A write changes the field only while the capability input is 1, and a write of the reserved code 11 leaves the field unchanged.
- R4: The list index output equals the frame index input modulo 1024, 512 or 256, for size codes 00, 01 and 10 respectively.
- R5: Writing 1 to bit 6 of 0x20, together with bit 5 set in the same write, makes the doorbell output 1. The doorbell holds until a cycle with eviction done high. At that clock edge the doorbell clears and status bit 5 sets.
- R6: Status bit 5 is cleared by writing 1 to bit 5 of 0x24. Writing 0 leaves it unchanged. If a clearing write and an eviction acknowledge fall on the same edge, the flag ends up set.
- R7: The interrupt output rises on the clock edge where a threshold tick is high while status bit 5 and enable bit 5 (offset 0x28) are both 1, and not before. It stays high until either bit is cleared, and it never rises while the enable is 0.
- R8: After run is set, the halted flag reads 0 from the second cycle after the write. After run is cleared, the flag stays 0 while pipeline idle is 0. It becomes 1 on the edge after pipeline idle is seen high.
- R9: Writing 1 to bit 1 of 0x20 holds the soft-reset output high for exactly RST_CYCLES cycles, with bit 1 reading 1 throughout. It resets the command and enable words and the halted flag. During this time all writes are ignored, including writes of 0 to bit 1.
- R10: Reads of any offset other than 0x20, 0x24 and 0x28 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| pflf_cap_i | input | 1 | Frame-list size is programmable when 1 |
| pipe_idle_i | input | 1 | Engine has no transaction in flight |
| evict_done_i | input | 1 | Engine finished evicting cached async state |
| thresh_tick_i | input | 1 | Interrupt-threshold boundary pulse |
| frame_idx_i | input | FIDX_W | Running frame index |
| run_o | output | 1 | Run request to the engine |
| pse_o | output | 1 | Periodic schedule enable |
| ase_o | output | 1 | Asynchronous schedule enable |
| fls_o | output | 2 | Frame-list size code |
| doorbell_o | output | 1 | Pending async-advance doorbell |
| soft_rst_o | output | 1 | Soft reset in progress |
| list_idx_o | output | 10 | Frame index masked to the list size |
| irq_o | output | 1 | Async-advance interrupt |

## Verification
Two events can meet on one edge and contend for status bit 5: an eviction acknowledge that sets the flag, and a software write of 1 that clears it. The bench drives the eviction pulse on the same edge as a clearing write to 0x24 and reads the flag back afterwards. It expects the flag to be set, because the acknowledge wins. A second collision is a threshold tick arriving on the edge that makes the interrupt conditions true. The bench places the tick exactly one edge apart from a probe and checks that the interrupt rises on that edge and not earlier. Every frame-list code is swept under both capability settings, and a strided sweep covers the frame index.

// File: rtl/hccs_pkg.sv
package hccs_pkg;

    localparam logic [7:0] OFS_CMD = 8'h20;
    localparam logic [7:0] OFS_STS = 8'h24;
    localparam logic [7:0] OFS_IEN = 8'h28;

    localparam int B_RUN   = 0;
    localparam int B_RST   = 1;
    localparam int B_FLS   = 2;
    localparam int B_PSE   = 4;
    localparam int B_ASE   = 5;
    localparam int B_DBELL = 6;
    localparam int B_AADV  = 5;
    localparam int B_HALT  = 12;

    localparam int LIST_W_MAX = 10;

    typedef enum logic [1:0] {
        FLS_1024 = 2'b00,
        FLS_512  = 2'b01,
        FLS_256  = 2'b10,
        FLS_RSVD = 2'b11
    } fls_e;

    typedef struct packed {
        logic run;
        logic pse;
        logic ase;
        fls_e fls;
        logic dbell;
    } cmd_t;

endpackage

// File: rtl/hccs_rst_timer.sv
module hccs_rst_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.active) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = CNT_W'(RST_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign active_o = tmr_q.active;

    AST_RST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && tmr_q.cnt != '0) |=> tmr_q.active); // R9

endmodule

// File: rtl/hccs_cmd_reg.sv
module hccs_cmd_reg
    import hccs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       wr_i,
    input  logic [6:0] wr_data_i,
    input  logic       pflf_i,
    input  logic       evict_i,
    output cmd_t       cmd_o,
    output logic       aadv_set_o
);
    cmd_t cmd_d, cmd_q;
    logic aadv_set;
    fls_e fls_wr;
    logic unused_rst_bit;

    assign unused_rst_bit = wr_data_i[B_RST];
    assign fls_wr = fls_e'(wr_data_i[B_FLS +: 2]);

    always_comb begin
        cmd_d    = cmd_q;
        aadv_set = 1'b0;
        if (clr_i) begin
            cmd_d = '0;
        end else begin
            if (cmd_q.dbell && evict_i) begin
                cmd_d.dbell = 1'b0;
                aadv_set    = 1'b1;
            end
            if (wr_i) begin
                cmd_d.run = wr_data_i[B_RUN];
                cmd_d.pse = wr_data_i[B_PSE];
                cmd_d.ase = wr_data_i[B_ASE];
                if (pflf_i && fls_wr != FLS_RSVD) begin
                    cmd_d.fls = fls_wr;
                end
                if (wr_data_i[B_DBELL] && wr_data_i[B_ASE]) begin
                    cmd_d.dbell = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign cmd_o      = cmd_q;
    assign aadv_set_o = aadv_set;

    AST_FLS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pflf_i && !clr_i) |=> $stable(cmd_q.fls)); // R3

    AST_DB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.dbell && !evict_i && !clr_i) |=> cmd_q.dbell); // R5

endmodule

// File: rtl/hccs_sts_reg.sv
module hccs_sts_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic idle_i,
    input  logic aadv_set_i,
    input  logic wr_sts_i,
    input  logic wr_ien_i,
    input  logic wr_bit_i,
    input  logic tick_i,
    output logic halted_o,
    output logic aadv_o,
    output logic aadv_en_o,
    output logic irq_o
);
    typedef struct packed {
        logic halted;
        logic aadv;
        logic aen;
        logic irq;
    } sts_t;

    sts_t sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (clr_i) begin
            sts_d.halted = 1'b1;
            sts_d.aadv   = 1'b0;
            sts_d.aen    = 1'b0;
            sts_d.irq    = 1'b0;
        end else begin
            if (run_i) begin
                sts_d.halted = 1'b0;
            end else if (idle_i) begin
                sts_d.halted = 1'b1;
            end
            if (wr_sts_i && wr_bit_i) begin
                sts_d.aadv = 1'b0;
            end
            if (aadv_set_i) begin
                sts_d.aadv = 1'b1;
            end
            if (wr_ien_i) begin
                sts_d.aen = wr_bit_i;
            end
            sts_d.irq = sts_d.aadv && sts_d.aen && (sts_q.irq || tick_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '{halted: 1'b1, aadv: 1'b0, aen: 1'b0, irq: 1'b0};
        end else begin
            sts_q <= sts_d;
        end
    end

    assign halted_o  = sts_q.halted;
    assign aadv_o    = sts_q.aadv;
    assign aadv_en_o = sts_q.aen;
    assign irq_o     = sts_q.irq;

    AST_HALT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q.halted) |-> ($past(idle_i) || $past(clr_i))); // R8

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q.irq) |-> $past(tick_i)); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts_i && wr_bit_i && !aadv_set_i) |=> !sts_q.aadv); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (aadv_set_i && !clr_i) |=> sts_q.aadv); // R6

endmodule

// File: rtl/hccs_list_idx.sv
module hccs_list_idx
    import hccs_pkg::*;
#(
    parameter int FIDX_W = 14,
    parameter int LIST_W = LIST_W_MAX
) (
    input  logic [FIDX_W-1:0] frame_i,
    input  fls_e              fls_i,
    output logic [LIST_W-1:0] idx_o
);
    logic [FIDX_W-1:0] unused_frame;

    assign unused_frame = frame_i;

    for (genvar i = 0; i < LIST_W; i++) begin : g_bit
        assign idx_o[i] = frame_i[i] & (i < (LIST_W - int'(fls_i)));
    end

endmodule

// File: rtl/usb_hc_cmdsts.sv
module usb_hc_cmdsts
    import hccs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIDX_W     = 14,
    parameter int RST_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    input  logic                  pflf_cap_i,
    input  logic                  pipe_idle_i,
    input  logic                  evict_done_i,
    input  logic                  thresh_tick_i,
    input  logic [FIDX_W-1:0]     frame_idx_i,
    output logic                  run_o,
    output logic                  pse_o,
    output logic                  ase_o,
    output logic [1:0]            fls_o,
    output logic                  doorbell_o,
    output logic                  soft_rst_o,
    output logic [LIST_W_MAX-1:0] list_idx_o,
    output logic                  irq_o
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IEN);

    logic wr_cmd, wr_sts, wr_ien, rst_start, clr_all;
    logic rst_active, aadv_set, halted, aadv, aadv_en;
    cmd_t cmd;
    logic [DATA_W-1:0] unused_wdata;

    assign unused_wdata = wdata_i;

    assign wr_cmd    = wr_en_i && (addr_i == A_CMD) && !rst_active;
    assign wr_sts    = wr_en_i && (addr_i == A_STS) && !rst_active;
    assign wr_ien    = wr_en_i && (addr_i == A_IEN) && !rst_active;
    assign rst_start = wr_cmd && wdata_i[B_RST];
    assign clr_all   = rst_start || rst_active;

    hccs_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (rst_start),
        .active_o (rst_active)
    );

    hccs_cmd_reg u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_all),
        .wr_i       (wr_cmd),
        .wr_data_i  (wdata_i[6:0]),
        .pflf_i     (pflf_cap_i),
        .evict_i    (evict_done_i),
        .cmd_o      (cmd),
        .aadv_set_o (aadv_set)
    );

    hccs_sts_reg u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_all),
        .run_i      (cmd.run),
        .idle_i     (pipe_idle_i),
        .aadv_set_i (aadv_set),
        .wr_sts_i   (wr_sts),
        .wr_ien_i   (wr_ien),
        .wr_bit_i   (wdata_i[B_AADV]),
        .tick_i     (thresh_tick_i),
        .halted_o   (halted),
        .aadv_o     (aadv),
        .aadv_en_o  (aadv_en),
        .irq_o      (irq_o)
    );

    hccs_list_idx #(.FIDX_W(FIDX_W), .LIST_W(LIST_W_MAX)) u_idx (
        .frame_i (frame_idx_i),
        .fls_i   (cmd.fls),
        .idx_o   (list_idx_o)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CMD) begin
            rdata_o[B_RUN]       = cmd.run;
            rdata_o[B_RST]       = rst_active;
            rdata_o[B_FLS +: 2]  = cmd.fls;
            rdata_o[B_PSE]       = cmd.pse;
            rdata_o[B_ASE]       = cmd.ase;
            rdata_o[B_DBELL]     = cmd.dbell;
        end else if (addr_i == A_STS) begin
            rdata_o[B_AADV]      = aadv;
            rdata_o[B_HALT]      = halted;
        end else if (addr_i == A_IEN) begin
            rdata_o[B_AADV]      = aadv_en;
        end
    end

    assign run_o      = cmd.run;
    assign pse_o      = cmd.pse;
    assign ase_o      = cmd.ase;
    assign fls_o      = cmd.fls;
    assign doorbell_o = cmd.dbell;
    assign soft_rst_o = rst_active;

    AST_DB_ACK_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(doorbell_o) && !soft_rst_o) |-> aadv); // R5

    AST_RST_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (!run_o && !pse_o && !ase_o && !doorbell_o && fls_o == 2'b00)); // R9

endmodule

// File: tb/usb_hc_cmdsts_tb.sv
module usb_hc_cmdsts_tb_top;
    localparam int RST = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap = 1'b0, idle = 1'b0, evict = 1'b0, tick = 1'b0;
    logic [13:0] fidx = '0;
    logic        run, pse, ase, db, srst, irq;
    logic [1:0]  fls;
    logic [9:0]  lidx;
    int          vecs = 0;
    int          errs = 0;
    logic [31:0] v;

    always #10 clk = ~clk;

    usb_hc_cmdsts #(.RST_CYCLES(RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .pflf_cap_i(cap), .pipe_idle_i(idle), .evict_done_i(evict),
        .thresh_tick_i(tick), .frame_idx_i(fidx), .run_o(run), .pse_o(pse), .ase_o(ase),
        .fls_o(fls), .doorbell_o(db), .soft_rst_o(srst), .list_idx_o(lidx), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        addr = a;
        #1 r = rdata;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 defaults, R10 unmapped
        rd(8'h20, v); chk("R1 cmd", v, 32'h0);
        rd(8'h24, v); chk("R1 sts", v, 32'h1000);
        rd(8'h28, v); chk("R1 ien", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 256; a += 4) begin
            if (a != 32'h20 && a != 32'h24 && a != 32'h28) begin
                rd(8'(a), v); chk("R10 unmapped", v, 32'h0);
            end
        end

        // R2 run/pse/ase sweep
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            w = (32'(k[0]) << 0) | (32'(k[1]) << 4) | (32'(k[2]) << 5);
            wr(8'h20, w);
            chk("R2 outs", {29'b0, ase, pse, run}, 32'(k));
            rd(8'h20, v); chk("R2 readback", v, w);
        end
        wr(8'h20, 32'h0);
        idle = 1'b1; cyc(); idle = 1'b0;

        // R8 halted handshake
        wr(8'h20, 32'h1);
        rd(8'h24, v); chk("R8 halted lag", v[12], 1'b1);
        cyc();
        rd(8'h24, v); chk("R8 running", v[12], 1'b0);
        wr(8'h20, 32'h0);
        for (int k = 0; k < 4; k++) begin
            cyc(); rd(8'h24, v); chk("R8 draining", v[12], 1'b0);
        end
        idle = 1'b1; cyc();
        rd(8'h24, v); chk("R8 halted after idle", v[12], 1'b1);

        // R3 frame-list size writability sweep
        for (int c = 0; c < 2; c++) begin
            for (int code = 0; code < 4; code++) begin
                logic [1:0] expc;
                cap = 1'b1; wr(8'h20, 32'h0);
                cap = c[0]; wr(8'h20, 32'(code) << 2);
                expc = (c == 1 && code != 3) ? 2'(code) : 2'b00;
                chk("R3 fls out", {30'b0, fls}, {30'b0, expc});
                rd(8'h20, v); chk("R3 fls readback", v, {28'b0, expc, 2'b00});
            end
        end

        // R4 list index masking
        cap = 1'b1;
        for (int code = 0; code < 3; code++) begin
            wr(8'h20, 32'(code) << 2);
            for (int f = 0; f < 16384; f += 37) begin
                fidx = 14'(f);
                #1 chk("R4 list idx", {22'b0, lidx}, 32'(f % (1024 >> code)));
            end
        end
        wr(8'h20, 32'h0);

        // R5 doorbell
        wr(8'h20, 32'h60);
        chk("R5 db set", {31'b0, db}, 32'h1);
        rd(8'h24, v); chk("R5 sts before ack", v[5], 1'b0);
        repeat (3) cyc();
        chk("R5 db held", {31'b0, db}, 32'h1);
        evict = 1'b1; cyc(); evict = 1'b0;
        chk("R5 db cleared", {31'b0, db}, 32'h0);
        rd(8'h24, v); chk("R5 sts set", v[5], 1'b1);
        chk("R7 no irq when disabled", {31'b0, irq}, 32'h0);

        // R6 write-one-to-clear
        wr(8'h24, 32'h0);
        rd(8'h24, v); chk("R6 write0 keeps", v[5], 1'b1);
        wr(8'h24, 32'h20);
        rd(8'h24, v); chk("R6 write1 clears", v[5], 1'b0);
        wr(8'h20, 32'h60);
        evict = 1'b1; wr(8'h24, 32'h20); evict = 1'b0;
        rd(8'h24, v); chk("R6 set wins", v[5], 1'b1);

        // R7 interrupt timing
        tick = 1'b1; cyc(); tick = 1'b0;
        chk("R7 tick with enable off", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'h20);
        rd(8'h28, v); chk("R7 ien readback", v, 32'h20);
        repeat (3) cyc();
        chk("R7 waits for tick", {31'b0, irq}, 32'h0);
        tick = 1'b1; #1 chk("R7 not before edge", {31'b0, irq}, 32'h0);
        cyc(); tick = 1'b0;
        chk("R7 rises at tick", {31'b0, irq}, 32'h1);
        repeat (2) cyc();
        chk("R7 held", {31'b0, irq}, 32'h1);
        wr(8'h24, 32'h20);
        chk("R7 drops on clear", {31'b0, irq}, 32'h0);

        // doorbell with async schedule off: illegal, result not checked
        $display("NOTE illegal usage: doorbell rung with async schedule disabled");
        wr(8'h20, 32'h40);
        evict = 1'b1; cyc(); evict = 1'b0;

        // R9 soft reset
        wr(8'h28, 32'h20);
        wr(8'h20, 32'h30);
        wr(8'h20, 32'h32);
        chk("R9 srst high", {31'b0, srst}, 32'h1);
        rd(8'h20, v); chk("R9 cmd in reset", v, 32'h2);
        rd(8'h28, v); chk("R9 ien cleared", v, 32'h0);
        rd(8'h24, v); chk("R9 halted", v[12], 1'b1);
        begin
            int n;
            n = 0;
            while (srst && n < 1000) begin
                if (n == 0) wr(8'h20, 32'h0);
                else if (n == 1) wr(8'h28, 32'h20);
                else cyc();
                n++;
            end
            chk("R9 duration", 32'(n), 32'(RST));
        end
        rd(8'h28, v); chk("R9 write ignored", v, 32'h0);
        rd(8'h20, v); chk("R9 cmd after", v, 32'h0);
        wr(8'h20, 32'h30);
        chk("R9 writes resume", {30'b0, ase, pse}, 32'h3);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule